// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of width `N` (default 32) over several clock cycles. It uses one adder of width N+1 and one shift register instead of a full array multiplier. Each cycle it looks at two adjacent multiplier bits: the bit now at the bottom of the working register and the bit shifted out in the previous cycle. From that pair it adds the multiplicand to the accumulating high half, subtracts it, or leaves the high half alone. It then shifts the whole working register right by one place, keeping the sign.

The working register is 2N+1 bits wide. The high N bits accumulate the partial product. The next N bits start out holding the multiplier and fill with product bits as it shifts. The lowest bit holds the previously shifted-out multiplier bit. A user pulses `start` with both operands while the block is idle. `busy` is then high for exactly N cycles, and `done` marks the cycle in which the 2N-bit product is first valid. The product stays on `product` until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures both operands, and `busy` is high from the next cycle on. A `start` sampled while `busy` is 1 is ignored: the run in progress and its result are unchanged.
- R3: After an accepted start, `busy` stays high for exactly N consecutive cycles, one per Booth iteration.
- R4: `done` is high for exactly one cycle, the first cycle with `busy` low after a run, and at no other time.
- R5: In the `done` cycle, `product` equals the signed product of the two operands captured at the accepted start. This includes the most negative value on either or both inputs.
- R6: While `busy` is 0, `product` holds the last completed result (zero before the first run) and does not change.
- R7: Changing `mcand` or `mplier` after the start cycle has no effect on the result of the run in progress.
- R8: Swapping the two operands gives the same product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication; accepted only while idle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when the product is first valid |
| product | output | 2N | Signed product; valid from the `done` cycle until the next accepted start |

## Verification
The bound checker runs on every cycle. It checks the single-cycle `done` pulse and its place right after `busy` falls. It counts the busy run against N, checks that `product` holds while idle, and compares the `done` result against a signed reference built from the operands captured at start. Only the bench scenarios show certain behaviours: that a start request during a run is dropped, that operand changes during a run are harmless, that swapped operands give the same result, and that the corner values (most negative times itself, times minus one, times the largest positive value) come out right.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Recode the current multiplier bit and the bit shifted out before it.
    function automatic booth_op_e booth_pick(input logic cur_bit, input logic prev_bit);
        booth_op_e op;
        unique case ({cur_bit, prev_bit})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_KEEP;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_step.sv
module booth_step
    import booth_mul_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [2*N:0]   work_i,
    input  logic [N-1:0]   mcand_i,
    output logic [2*N:0]   work_o
);
    localparam int WW = 2 * N + 1;

    booth_op_e      op;
    logic [N:0]     hi_ext;
    logic [N:0]     mc_ext;
    logic [N:0]     sum;

    assign op     = booth_pick(work_i[1], work_i[0]);
    assign hi_ext = {work_i[WW-1], work_i[WW-1:N+1]};
    assign mc_ext = {mcand_i[N-1], mcand_i};

    always_comb begin
        unique case (op)
            OP_ADD:  sum = hi_ext + mc_ext;
            OP_SUB:  sum = hi_ext + (~mc_ext) + {{N{1'b0}}, 1'b1};
            default: sum = hi_ext;
        endcase
    end

    // Arithmetic right shift: sum[N] carries the true sign into the top bit.
    assign work_o = {sum, work_i[N:1]};

endmodule

// File: rtl/booth_seq.sv
module booth_seq
    import booth_mul_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic advance
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    seq_state_e     state;
    logic [CW-1:0]  iter;

    assign busy    = (state == ST_RUN);
    assign load    = start && (state == ST_IDLE);
    assign advance = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        iter  <= '0;
                    end
                end
                ST_RUN: begin
                    if (iter == LAST) begin
                        state <= ST_IDLE;
                        iter  <= '0;
                        done  <= 1'b1;
                    end else begin
                        iter <= iter + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_mul_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N-1:0]     mcand,
    input  logic [N-1:0]     mplier,
    output logic             busy,
    output logic             done,
    output logic [2*N-1:0]   product
);
    localparam int WW = 2 * N + 1;

    logic [WW-1:0]  work_q;
    logic [WW-1:0]  work_nxt;
    logic [N-1:0]   mcand_q;
    logic           load;
    logic           advance;

    booth_seq #(.N(N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .advance (advance)
    );

    booth_step #(.N(N)) u_step (
        .work_i  (work_q),
        .mcand_i (mcand_q),
        .work_o  (work_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= '0;
            mcand_q <= '0;
        end else if (load) begin
            work_q  <= {{N{1'b0}}, mplier, 1'b0};
            mcand_q <= mcand;
        end else if (advance) begin
            work_q  <= work_nxt;
        end
    end

    assign product = work_q[WW-1:1];

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int N = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [N-1:0]     mcand,
    input logic [N-1:0]     mplier,
    input logic             busy,
    input logic             done,
    input logic [2*N-1:0]   product
);
    localparam int CW = $clog2(N + 2);

    logic [CW-1:0]      run_len;
    logic [N-1:0]       cap_a;
    logic [N-1:0]       cap_b;
    logic signed [2*N-1:0] ref_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else begin
            if (start && !busy) begin
                cap_a   <= mcand;
                cap_b   <= mplier;
                run_len <= '0;
            end else if (busy) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    assign ref_prod = $signed({{N{cap_a[N-1]}}, cap_a}) * $signed({{N{cap_b[N-1]}}, cap_b});

    // R4: done lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: done only right after busy falls
    a_r4_done_after_run: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R4: falling busy always brings done
    a_r4_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3: busy run length is N
    a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == CW'(N)));

    // R2: accepted start raises busy
    a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5: result matches signed reference
    a_r5_product_value: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_prod));

    // R6: idle product holds
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(product));

endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_booth_mul_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_mul_bench.sv
module booth_mul_bench;
    localparam int N = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [N-1:0]     mcand = '0;
    logic [N-1:0]     mplier = '0;
    logic             busy;
    logic             done;
    logic [2*N-1:0]   product;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    booth_mul #(.N(N)) u_booth_mul (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    // Behavioural reference: counts down the iterations, computes the result
    // with native signed arithmetic.
    logic          m_busy = 1'b0;
    logic          m_done = 1'b0;
    int            m_left = 0;
    longint        m_a = 0;
    longint        m_b = 0;
    logic [63:0]   m_prod = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_left <= 0;
            m_prod <= '0;
        end else if (m_busy) begin
            if (m_left == 1) begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
                m_prod <= 64'(m_a * m_b);
            end else begin
                m_left <= m_left - 1;
                m_done <= 1'b0;
            end
        end else begin
            m_done <= 1'b0;
            if (start) begin
                m_busy <= 1'b1;
                m_left <= N;
                m_a    <= longint'($signed(mcand));
                m_b    <= longint'($signed(mplier));
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            tests = tests + 1;
            if (busy !== m_busy) begin
                fails = fails + 1;
                $display("FAIL R3 busy: actual %b expected %b at %0t", busy, m_busy, $time);
            end
            tests = tests + 1;
            if (done !== m_done) begin
                fails = fails + 1;
                $display("FAIL R4 done: actual %b expected %b at %0t", done, m_done, $time);
            end
            if (!m_busy) begin
                tests = tests + 1;
                if (product !== m_prod) begin
                    fails = fails + 1;
                    $display("FAIL R6 product hold: actual %h expected %h at %0t", product, m_prod, $time);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Run one product; optionally poke a second start and scramble operands mid-run.
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input string tag, input bit poke, output logic [63:0] res);
        longint exp_v;
        exp_v = longint'($signed(a)) * longint'($signed(b));
        @(negedge clk);
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        @(negedge clk);
        start  = 1'b0;
        mcand  = $urandom();
        mplier = $urandom();
        if (poke) begin
            @(negedge clk);
            start  = 1'b1;
            mcand  = 32'h1234_5678;
            mplier = 32'h7654_3210;
            @(negedge clk);
            start  = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        res = product;
        check(tag, product, 64'(exp_v));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

    initial begin
        logic [63:0] r1;
        logic [63:0] r2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check("R1 busy in reset", 64'(busy), 64'd0);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 product in reset", product, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 product after reset", product, 64'd0);

        run_op(-32'sd5, 32'sd6, "R5 small mixed sign", 1'b0, r1);
        run_op(32'sd6, -32'sd5, "R8 swapped operands", 1'b0, r2);
        check("R8 swap equal", r2, r1);
        run_op(MINV, MINV, "R5 most negative squared", 1'b0, r1);
        run_op(MINV, -32'sd1, "R5 most negative times -1", 1'b0, r1);
        run_op(-32'sd1, MINV, "R8 -1 times most negative", 1'b0, r1);
        run_op(MINV, MAXV, "R5 most negative times max", 1'b0, r1);
        run_op(MAXV, MAXV, "R5 max squared", 1'b0, r1);
        run_op(32'd0, MINV, "R5 zero operand", 1'b0, r1);
        run_op(32'hAAAA_AAAA, 32'h5555_5555, "R5 alternating bits", 1'b0, r1);
        run_op(32'sd7, -32'sd9, "R2 start during run ignored", 1'b1, r1);
        run_op(32'sd1000, 32'sd3, "R7 operand change mid-run", 1'b0, r1);

        for (int i = 0; i < 150; i++) begin
            logic [N-1:0] a;
            logic [N-1:0] b;
            a = $urandom();
            b = $urandom();
            run_op(a, b, "R5 random", i[0], r1);
            run_op(b, a, "R8 random swap", 1'b0, r2);
            check("R8 random swap equal", r2, r1);
            repeat (i % 3) @(negedge clk);
        end

        // R6: idle product holds for many cycles
        repeat (20) @(negedge clk);
        check("R6 idle hold", product, r2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule